// File: doc/BRIEF.md
# Configurable Hardware Stack Pointer Unit

This block holds the pointer of a hardware stack and runs each push or pop as a short sequence of accesses to one single-port memory. It drives the memory's address, enable, write strobe and write data. Read data comes back combinationally from the memory in the same cycle as the address. Two elaboration parameters choose the stack discipline. `GROW_UP` sets whether new entries go to rising or falling addresses. `LAST_FULL` sets whether the pointer marks the most recently written entry or the free slot just beyond it. Together they give four disciplines, and these differ in whether the pointer moves before or after the memory access.

`BASE` is the address of the first entry and `LIMIT` is the address of the last usable entry. The stack therefore holds |LIMIT − BASE| + 1 entries. A push onto a full stack or a pop from an empty stack is refused and reported by a one-cycle flag. Each accepted command runs in two named states chosen from `ST_PUSH_ADV` (move the pointer forward), `ST_PUSH_WR` (write memory), `ST_POP_RD` (read memory) and `ST_POP_RET` (move the pointer back). All commands start from and return to `ST_IDLE`.

Top module: `stack_ptr_unit`

## Requirements
- R1: When reset is released, `sp` holds the empty value and `busy`, `overflow`, `underflow` and `pop_valid` are low. The empty value is `BASE` when `LAST_FULL`=0 and `BASE` minus one step when `LAST_FULL`=1.
- R2: A command sampled in `ST_IDLE` raises `busy` for exactly the two following cycles and then returns to idle. Requests present while `busy` is high are ignored.
- R3: With `LAST_FULL`=1, a push moves `sp` one step forward in its first cycle (`ST_PUSH_ADV`). It writes the data to the new `sp` address in its second cycle (`ST_PUSH_WR`).
- R4: With `LAST_FULL`=1, a pop reads the memory at `sp` in its first cycle (`ST_POP_RD`). It moves `sp` one step back in its second cycle (`ST_POP_RET`).
- R5: With `LAST_FULL`=0, a push writes the data at `sp` in its first cycle (`ST_PUSH_WR`). It moves `sp` one step forward in its second cycle (`ST_PUSH_ADV`).
- R6: With `LAST_FULL`=0, a pop moves `sp` one step back in its first cycle (`ST_POP_RET`). It reads the memory at the new `sp` in its second cycle (`ST_POP_RD`).
- R7: One step forward is +1 when `GROW_UP`=1 and −1 (modulo 2^ADDR_W) when `GROW_UP`=0. With k entries already stored, a push uses address `BASE` + k·step in every discipline.
- R8: A push while the stack holds |LIMIT−BASE|+1 entries raises `overflow` for exactly the one cycle after the request. It makes no memory access, leaves `sp` unchanged and keeps `busy` low.
- R9: A pop while the stack is empty raises `underflow` for exactly the one cycle after the request. It makes no memory access, leaves `sp` unchanged and keeps `busy` low.
- R10: Each accepted pop returns the most recently pushed, not yet popped data on `pop_data`. `pop_valid` is high for the single cycle after the pop's last state.
- R11: When `push_req` and `pop_req` are both high in `ST_IDLE`, the push is taken and the pop is dropped. This includes the case where that push is refused as an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Push request, sampled in idle |
| pop_req | input | 1 | Pop request, sampled in idle |
| push_data | input | DATA_W | Data to push, captured with the request |
| busy | output | 1 | High while a command is in progress |
| sp | output | ADDR_W | Current stack pointer |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable (with `mem_en`) |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, combinational from `mem_addr` |
| pop_data | output | DATA_W | Data returned by the last pop |
| pop_valid | output | 1 | One-cycle pulse when `pop_data` is new |
| overflow | output | 1 | One-cycle pulse on a refused push |
| underflow | output | 1 | One-cycle pulse on a refused pop |

## Verification
The bench builds four copies of the block side by side, each with a depth of four: `GROW_UP` set to 1 and 0, each combined with `LAST_FULL` set to 1 and 0. `BASE` is 0x40 for all copies. `LIMIT` is 0x43 for the upward copies and 0x3D for the downward ones. A command stream drives all four copies at once, so the same LIFO results must appear under every discipline. The address and the cycle of every memory access expose each copy's own order of pointer move and access. The upward last-full copy starts from 0x3F and the downward last-full copy starts from 0x41, so the empty-pointer offset is checked in both directions.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_ADV,
        ST_PUSH_WR,
        ST_POP_RD,
        ST_POP_RET
    } stk_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_PUSH,
        CMD_POP
    } stk_cmd_e;

endpackage

// File: rtl/stk_bounds.sv
module stk_bounds #(
    parameter int unsigned ADDR_W    = 8,
    parameter bit          GROW_UP   = 1'b1,
    parameter bit          LAST_FULL = 1'b1,
    parameter int unsigned BASE      = 64,
    parameter int unsigned LIMIT     = 67
) (
    input  logic [ADDR_W-1:0] sp_cur,
    output logic [ADDR_W-1:0] sp_fwd,
    output logic [ADDR_W-1:0] sp_back,
    output logic              is_empty,
    output logic              is_full
);
    localparam logic [ADDR_W-1:0] STEP     = GROW_UP ? ADDR_W'(1) : {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] LIMIT_A  = ADDR_W'(LIMIT);
    localparam logic [ADDR_W-1:0] EMPTY_SP = LAST_FULL ? ADDR_W'(BASE_A - STEP) : BASE_A;
    localparam logic [ADDR_W-1:0] FULL_SP  = LAST_FULL ? LIMIT_A : ADDR_W'(LIMIT_A + STEP);

    always_comb begin
        sp_fwd   = sp_cur + STEP;
        sp_back  = sp_cur - STEP;
        is_empty = (sp_cur == EMPTY_SP);
        is_full  = (sp_cur == FULL_SP);
    end
endmodule

// File: rtl/stk_cmd_sel.sv
module stk_cmd_sel
    import stk_pkg::*;
(
    input  logic idle,
    input  logic push_req,
    input  logic pop_req,
    input  logic is_empty,
    input  logic is_full,
    output logic start_push,
    output logic start_pop,
    output logic rej_push,
    output logic rej_pop
);
    stk_cmd_e cmd;

    always_comb begin
        if (!idle)         cmd = CMD_NONE;
        else if (push_req) cmd = CMD_PUSH;
        else if (pop_req)  cmd = CMD_POP;
        else               cmd = CMD_NONE;
    end

    always_comb begin
        start_push = 1'b0;
        start_pop  = 1'b0;
        rej_push   = 1'b0;
        rej_pop    = 1'b0;
        unique case (cmd)
            CMD_PUSH: begin
                start_push = !is_full;
                rej_push   = is_full;
            end
            CMD_POP: begin
                start_pop = !is_empty;
                rej_pop   = is_empty;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter bit LAST_FULL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_push,
    input  logic start_pop,
    output logic idle,
    output logic busy,
    output logic acc_en,
    output logic acc_we,
    output logic ptr_fwd,
    output logic ptr_back,
    output logic pop_done
);
    stk_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: the order of phases follows the empty convention
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_push)     state_d = LAST_FULL ? ST_PUSH_ADV : ST_PUSH_WR;
                else if (start_pop) state_d = LAST_FULL ? ST_POP_RD : ST_POP_RET;
            end
            ST_PUSH_ADV: state_d = LAST_FULL ? ST_PUSH_WR : ST_IDLE;
            ST_PUSH_WR:  state_d = LAST_FULL ? ST_IDLE : ST_PUSH_ADV;
            ST_POP_RD:   state_d = LAST_FULL ? ST_POP_RET : ST_IDLE;
            ST_POP_RET:  state_d = LAST_FULL ? ST_IDLE : ST_POP_RD;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        idle     = 1'b0;
        busy     = 1'b1;
        acc_en   = 1'b0;
        acc_we   = 1'b0;
        ptr_fwd  = 1'b0;
        ptr_back = 1'b0;
        pop_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idle = 1'b1;
                busy = 1'b0;
            end
            ST_PUSH_ADV: ptr_fwd = 1'b1;
            ST_PUSH_WR: begin
                acc_en = 1'b1;
                acc_we = 1'b1;
            end
            ST_POP_RD: begin
                acc_en   = 1'b1;
                pop_done = !LAST_FULL;
            end
            ST_POP_RET: begin
                ptr_back = 1'b1;
                pop_done = LAST_FULL;
            end
            default: begin
                idle = 1'b1;
                busy = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 16,
    parameter bit          GROW_UP   = 1'b1,
    parameter bit          LAST_FULL = 1'b1,
    parameter int unsigned BASE      = 64,
    parameter int unsigned LIMIT     = 67
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] push_data,
    output logic              busy,
    output logic [ADDR_W-1:0] sp,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    output logic              overflow,
    output logic              underflow
);
    localparam logic [ADDR_W-1:0] STEP     = GROW_UP ? ADDR_W'(1) : {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] EMPTY_SP = LAST_FULL ? ADDR_W'(ADDR_W'(BASE) - STEP)
                                                       : ADDR_W'(BASE);

    logic [ADDR_W-1:0] sp_q, sp_fwd, sp_back;
    logic [DATA_W-1:0] wdata_q, pdata_q;
    logic is_empty, is_full, idle;
    logic start_push, start_pop, rej_push, rej_pop;
    logic acc_en, acc_we, ptr_fwd, ptr_back, pop_done;
    logic pvalid_q, ovf_q, unf_q;

    stk_bounds #(
        .ADDR_W(ADDR_W), .GROW_UP(GROW_UP), .LAST_FULL(LAST_FULL),
        .BASE(BASE), .LIMIT(LIMIT)
    ) u_bounds (
        .sp_cur(sp_q), .sp_fwd(sp_fwd), .sp_back(sp_back),
        .is_empty(is_empty), .is_full(is_full)
    );

    stk_cmd_sel u_sel (
        .idle(idle), .push_req(push_req), .pop_req(pop_req),
        .is_empty(is_empty), .is_full(is_full),
        .start_push(start_push), .start_pop(start_pop),
        .rej_push(rej_push), .rej_pop(rej_pop)
    );

    stk_seq #(.LAST_FULL(LAST_FULL)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_push(start_push), .start_pop(start_pop),
        .idle(idle), .busy(busy), .acc_en(acc_en), .acc_we(acc_we),
        .ptr_fwd(ptr_fwd), .ptr_back(ptr_back), .pop_done(pop_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sp_q <= EMPTY_SP;
        else if (ptr_fwd)  sp_q <= sp_fwd;
        else if (ptr_back) sp_q <= sp_back;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          wdata_q <= '0;
        else if (start_push) wdata_q <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pdata_q <= '0;
        else if (acc_en && !acc_we) pdata_q <= mem_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pvalid_q <= 1'b0;
            ovf_q    <= 1'b0;
            unf_q    <= 1'b0;
        end else begin
            pvalid_q <= pop_done;
            ovf_q    <= rej_push;
            unf_q    <= rej_pop;
        end
    end

    assign sp        = sp_q;
    assign mem_en    = acc_en;
    assign mem_we    = acc_en & acc_we;
    assign mem_addr  = sp_q;
    assign mem_wdata = wdata_q;
    assign pop_data  = pdata_q;
    assign pop_valid = pvalid_q;
    assign overflow  = ovf_q;
    assign underflow = unf_q;
endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [ADDR_W-1:0] sp,
    input logic              mem_en,
    input logic              overflow,
    input logic              underflow,
    input logic              pop_valid
);
    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |=> !busy);

    // R2
    sp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> $stable(sp));

    // R7
    access_in_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> busy);

    // R8
    no_overflow_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (!busy && !mem_en && $stable(sp)));

    // R9
    no_underflow_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (!busy && !mem_en && $stable(sp)));

    // R10
    pop_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> !busy);

    // R11
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({overflow, underflow, pop_valid}));
endmodule

bind stack_ptr_unit stk_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .sp(sp), .mem_en(mem_en),
    .overflow(overflow), .underflow(underflow), .pop_valid(pop_valid)
);

// File: tb/tb_stack_ptr_unit.sv
module stk_lane #(
    parameter bit          GROW_UP   = 1'b1,
    parameter bit          LAST_FULL = 1'b1,
    parameter int unsigned LIMIT     = 67
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_req,
    input  logic        pop_req,
    input  logic [15:0] push_data,
    output logic        busy,
    output logic [7:0]  sp,
    output logic [15:0] pop_data,
    output logic        pop_valid,
    output logic        overflow,
    output logic        underflow,
    output logic [7:0]  wr_addr,
    output logic [15:0] wr_data,
    output logic [1:0]  wr_phase,
    output logic [7:0]  rd_addr,
    output logic [1:0]  rd_phase,
    output logic [15:0] acc_n
);
    logic        mem_en, mem_we;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [15:0] mem [256];
    logic [1:0]  cyc;

    stack_ptr_unit #(
        .ADDR_W(8), .DATA_W(16), .GROW_UP(GROW_UP), .LAST_FULL(LAST_FULL),
        .BASE(64), .LIMIT(LIMIT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
        .push_data(push_data), .busy(busy), .sp(sp), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .pop_data(pop_data), .pop_valid(pop_valid),
        .overflow(overflow), .underflow(underflow)
    );

    assign mem_rdata = mem[mem_addr];

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        wr_addr = '0; wr_data = '0; wr_phase = '0;
        rd_addr = '0; rd_phase = '0; acc_n = '0; cyc = '0;
    end

    always @(posedge clk) begin
        if (mem_en && mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_addr  <= mem_addr;
            wr_data  <= mem_wdata;
            wr_phase <= cyc + 2'd1;
        end
        if (mem_en && !mem_we) begin
            rd_addr  <= mem_addr;
            rd_phase <= cyc + 2'd1;
        end
        if (mem_en) acc_n <= acc_n + 16'd1;
        cyc <= busy ? cyc + 2'd1 : 2'd0;
    end
endmodule

module tb_stack_ptr_unit;
    localparam int NV    = 16;
    localparam int DEPTH = 4;
    // op[17:16]: 00 idle, 01 push, 10 pop, 11 push and pop together
    localparam logic [17:0] VEC [NV] = '{
        {2'b01, 16'h1111}, {2'b01, 16'h2222}, {2'b10, 16'h0000}, {2'b01, 16'h3333},
        {2'b01, 16'h4444}, {2'b01, 16'h5555}, {2'b01, 16'h6666}, {2'b11, 16'h7777},
        {2'b10, 16'h0000}, {2'b10, 16'h0000}, {2'b10, 16'h0000}, {2'b10, 16'h0000},
        {2'b10, 16'h0000}, {2'b11, 16'h8888}, {2'b10, 16'h0000}, {2'b00, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_req = 1'b0, pop_req = 1'b0;
    logic [15:0] push_data = '0;

    logic        busy_v [4], pvalid_v [4], ovf_v [4], unf_v [4];
    logic [7:0]  sp_v [4], wra_v [4], rda_v [4];
    logic [15:0] pd_v [4], wrd_v [4], acc_v [4];
    logic [1:0]  wrp_v [4], rdp_v [4];

    int n_chk = 0, n_bad = 0, cnt = 0;
    int q[$];
    bit done = 0;

    always #2 clk = ~clk;

    stk_lane #(.GROW_UP(1), .LAST_FULL(1), .LIMIT(67)) l0 (
        clk, rst_n, push_req, pop_req, push_data, busy_v[0], sp_v[0], pd_v[0], pvalid_v[0],
        ovf_v[0], unf_v[0], wra_v[0], wrd_v[0], wrp_v[0], rda_v[0], rdp_v[0], acc_v[0]);
    stk_lane #(.GROW_UP(1), .LAST_FULL(0), .LIMIT(67)) l1 (
        clk, rst_n, push_req, pop_req, push_data, busy_v[1], sp_v[1], pd_v[1], pvalid_v[1],
        ovf_v[1], unf_v[1], wra_v[1], wrd_v[1], wrp_v[1], rda_v[1], rdp_v[1], acc_v[1]);
    stk_lane #(.GROW_UP(0), .LAST_FULL(1), .LIMIT(61)) l2 (
        clk, rst_n, push_req, pop_req, push_data, busy_v[2], sp_v[2], pd_v[2], pvalid_v[2],
        ovf_v[2], unf_v[2], wra_v[2], wrd_v[2], wrp_v[2], rda_v[2], rdp_v[2], acc_v[2]);
    stk_lane #(.GROW_UP(0), .LAST_FULL(0), .LIMIT(61)) l3 (
        clk, rst_n, push_req, pop_req, push_data, busy_v[3], sp_v[3], pd_v[3], pvalid_v[3],
        ovf_v[3], unf_v[3], wra_v[3], wrd_v[3], wrp_v[3], rda_v[3], rdp_v[3], acc_v[3]);

    function automatic bit lane_lf(int i);
        return (i == 0) || (i == 2);
    endfunction

    function automatic int slot(int i, int k);
        return (i < 2) ? int'(8'(64 + k)) : int'(8'(64 - k));
    endfunction

    function automatic int exp_sp(int i, int c);
        return lane_lf(i) ? slot(i, c - 1) : slot(i, c);
    endfunction

    task automatic chk(input string req, input int lane, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s lane %0d: actual %0h expected %0h", req, lane, act, exp);
        end
    endtask

    task automatic do_op(input bit p, input bit o, input logic [15:0] d);
        bit eff_push, eff_pop, rej;
        int acc0 [4];
        int expd;
        eff_push = p;
        eff_pop  = o && !p;
        rej = eff_push ? (cnt == DEPTH) : (eff_pop ? (cnt == 0) : 1'b0);
        for (int i = 0; i < 4; i++) acc0[i] = int'(acc_v[i]);
        @(negedge clk);
        push_req = p; pop_req = o; push_data = d;
        @(negedge clk);
        push_req = 0; pop_req = 0;
        if (!eff_push && !eff_pop) begin
            for (int i = 0; i < 4; i++) chk("R2 idle", i, int'(busy_v[i]), 0);
            return;
        end
        if (rej) begin
            for (int i = 0; i < 4; i++) begin
                chk(eff_push ? "R8 overflow" : "R9 underflow", i,
                    eff_push ? int'(ovf_v[i]) : int'(unf_v[i]), 1);
                chk(p && o ? "R11 both-rejected flag" : "R9/R8 other flag", i,
                    eff_push ? int'(unf_v[i]) : int'(ovf_v[i]), 0);
                chk("R8 busy", i, int'(busy_v[i]), 0);
                chk("R9 sp", i, int'(sp_v[i]), exp_sp(i, cnt));
            end
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                chk("R8 pulse", i, int'(ovf_v[i]) + int'(unf_v[i]), 0);
                chk("R9 no access", i, int'(acc_v[i]), acc0[i]);
            end
            return;
        end
        for (int i = 0; i < 4; i++) chk("R2 busy1", i, int'(busy_v[i]), 1);
        @(negedge clk);
        for (int i = 0; i < 4; i++) chk("R2 busy2", i, int'(busy_v[i]), 1);
        @(negedge clk);
        if (eff_push) begin
            for (int i = 0; i < 4; i++) begin
                chk(lane_lf(i) ? "R3 addr" : "R5 addr", i, int'(wra_v[i]), slot(i, cnt));
                chk(lane_lf(i) ? "R3 phase" : "R5 phase", i, int'(wrp_v[i]), lane_lf(i) ? 2 : 1);
                chk(p && o ? "R11 push taken" : "R7 data", i, int'(wrd_v[i]), int'(d));
            end
            q.push_back(int'(d));
            cnt++;
        end else begin
            expd = q.pop_back();
            cnt--;
            for (int i = 0; i < 4; i++) begin
                chk(lane_lf(i) ? "R4 addr" : "R6 addr", i, int'(rda_v[i]), slot(i, cnt));
                chk(lane_lf(i) ? "R4 phase" : "R6 phase", i, int'(rdp_v[i]), lane_lf(i) ? 1 : 2);
                chk("R10 valid", i, int'(pvalid_v[i]), 1);
                chk("R10 data", i, int'(pd_v[i]), expd);
            end
        end
        for (int i = 0; i < 4; i++) begin
            chk("R2 done", i, int'(busy_v[i]), 0);
            chk("R7 sp", i, int'(sp_v[i]), exp_sp(i, cnt));
            chk("R2 one access", i, int'(acc_v[i]), acc0[i] + 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            chk("R1 sp", i, int'(sp_v[i]), exp_sp(i, 0));
            chk("R1 flags", i, int'(busy_v[i]) + int'(ovf_v[i]) + int'(unf_v[i]) + int'(pvalid_v[i]), 0);
        end
        for (int v = 0; v < NV; v++)
            do_op(VEC[v][16], VEC[v][17], VEC[v][15:0]);

        // R2: request held across a whole command gives one push only
        @(negedge clk);
        push_req = 1; push_data = 16'hABCD;
        repeat (3) @(negedge clk);
        push_req = 0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            chk("R2 held request", i, int'(sp_v[i]), exp_sp(i, 1));
            chk("R2 held busy", i, int'(busy_v[i]), 0);
        end
        q.push_back(16'hABCD);
        cnt = 1;
        do_op(1'b0, 1'b1, 16'h0);
        // R9: pop on empty after draining
        do_op(1'b0, 1'b1, 16'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule